// File: doc/BRIEF.md
# Sector Erase Sequencer with Completion Polling

This block sits on the host side of a parallel NOR-style flash write bus and carries out a multi-sector erase for whoever requests it. A requester supplies a count of sectors and their addresses over a valid/ready handshake. The controller then drives the command preamble onto the bus. That preamble is two unlock writes, a setup write and two further unlock writes. It follows with one sector-erase write per requested sector. All of these writes are packed with no idle cycle between them, so the device's short acceptance window between sector commands is always met.

Once the last command is written, the block waits for the device to finish. It watches one of two completion sources, chosen per request. In status-read mode it releases the bus, then at regular intervals performs a single read at the first requested sector address and tests the status bit. That address is kept in a holding register because the device stops latching addresses once it returns to read mode. In ready/busy mode it never reads and instead samples the ready/busy line at the same interval. A bounded wait produces a timeout. The result is reported as a one-cycle done pulse with an error flag. A synchronous reset abandons any operation in flight, and the next request replays the full sequence so that an interrupted erase can be redone.

Top module: `sector_wipe_ctrl`

## Requirements
- R1: After reset the outputs are: `req_ready`=1, `fl_we_n`=1, `fl_oe_n`=1, `fl_own`=0, `done`=0, `done_err`=0, `fl_addr`=0, `fl_wdata`=0.
- R2: Every bus write occupies STROBE_CYC+1 cycles. `fl_we_n` is low for the first STROBE_CYC cycles and high for the final cycle. `fl_addr` and `fl_wdata` stay constant over all of them.
- R3: The writes appear in this order, each address/data in hex: 555/AA, 2AA/55, 555/80, 555/AA, 2AA/55, then sector[0]/30, then sector[i]/30 for i = 1..count-1. Sector i is `req_sectors[i*ADDR_W +: ADDR_W]`. Each write slot follows the previous one with no cycle in between.
- R4: In status-read mode (`req_use_rdy`=0), the block releases the bus for POLL_GAP cycles once the writes end. It then drives one read cycle with `fl_oe_n`=0, `fl_own`=1 and `fl_addr` = sector[0]. Bit 7 of `fl_rdata` is sampled at the end of that cycle. If it is 1 the erase is complete; otherwise another gap and read follow, always at the same address.
- R5: In ready/busy mode (`req_use_rdy`=1), no read cycles are issued. `fl_ry_by` is sampled at the end of every POLL_GAP-th waiting cycle, and 1 means complete.
- R6: If no completion is seen within TIMEOUT_CYC waiting cycles, the operation ends with `done_err`=1. A completion seen in the final waiting cycle takes precedence and ends it with `done_err`=0.
- R7: The cycle after completion or timeout, `done` is high for exactly one cycle. `done_err` is 0 for success. `req_ready` returns the next cycle.
- R8: A request with count 0 or count above MAX_SECT produces `done` with `done_err`=1 in the following cycle, and no bus activity.
- R9: `req_ready` is high only while idle. A `req_valid` presented while an operation is in flight has no effect on the bus or on the outcome.
- R10: A synchronous reset in mid-operation returns the block to the R1 state. The next request restarts from the first unlock write.
- R11: While `fl_own` is 0, `fl_we_n` and `fl_oe_n` are high and `fl_addr` and `fl_wdata` are zero. `fl_we_n` and `fl_oe_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Erase request offered |
| req_ready | output | 1 | Controller idle, request taken when valid |
| req_count | input | $clog2(MAX_SECT+1) | Number of sectors in the request |
| req_use_rdy | input | 1 | 1: watch ready/busy line, 0: poll status bit |
| req_sectors | input | MAX_SECT*ADDR_W | Sector addresses, entry i at bits i*ADDR_W |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_wdata | output | DATA_W | Flash write data |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_oe_n | output | 1 | Read enable, active low |
| fl_rdata | input | DATA_W | Flash read data (bit 7 is status) |
| fl_ry_by | input | 1 | Ready/busy line, high when finished |
| fl_own | output | 1 | Controller is using the flash bus this cycle |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Error qualifier for done (timeout or bad count) |

## Verification
The in-RTL assertions watch several properties on every cycle. They check that address and data hold steady across each write slot and that a new strobe starts right after each recovery cycle. They check that strobe and read enable never overlap, that the bus is quiet whenever it is released, and that the held poll address does not move during an operation. They also check that reads last a single cycle, that ready/busy mode issues no reads, and that the wait counter never passes its limit. The exact command order, the read spacing, the choice between completion and timeout on the last waiting cycle, and the restart after a mid-write reset are shown only by the bench's scenarios. The bench compares against its own timeline model every cycle.

// File: rtl/wipe_pkg.sv
package wipe_pkg;

    // Number of fixed writes ahead of the first sector command
    localparam int UNLOCK_STEPS = 5;
    // Status bit tested during read polling
    localparam int POLL_BIT     = 7;

    localparam logic [11:0] KEY_ADDR_A = 12'h555;
    localparam logic [11:0] KEY_ADDR_B = 12'h2AA;
    localparam logic [7:0]  KEY_DATA_A = 8'hAA;
    localparam logic [7:0]  KEY_DATA_B = 8'h55;
    localparam logic [7:0]  SETUP_DATA = 8'h80;
    localparam logic [7:0]  SECT_DATA  = 8'h30;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_WATCH,
        ST_DONE
    } ctl_state_e;

    typedef enum logic {
        PH_GAP,
        PH_READ
    } watch_phase_e;

    typedef struct packed {
        logic [11:0] addr;
        logic [7:0]  data;
    } prefix_cmd_t;

    // Fixed preamble: unlock pair, setup, unlock pair
    function automatic prefix_cmd_t prefix_cmd(input logic [2:0] idx);
        prefix_cmd_t c;
        case (idx)
            3'd0:    c = '{addr: KEY_ADDR_A, data: KEY_DATA_A};
            3'd1:    c = '{addr: KEY_ADDR_B, data: KEY_DATA_B};
            3'd2:    c = '{addr: KEY_ADDR_A, data: SETUP_DATA};
            3'd3:    c = '{addr: KEY_ADDR_A, data: KEY_DATA_A};
            3'd4:    c = '{addr: KEY_ADDR_B, data: KEY_DATA_B};
            default: c = '{addr: 12'h000,    data: 8'h00};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/wipe_write_seq.sv
module wipe_write_seq
    import wipe_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int MAX_SECT   = 4,
    parameter int STROBE_CYC = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       active,
    input  logic [CNT_W-1:0]           count,
    input  logic [MAX_SECT*ADDR_W-1:0] sectors,
    output logic [ADDR_W-1:0]          wr_addr,
    output logic [DATA_W-1:0]          wr_data,
    output logic                       wr_strobe,
    output logic                       last
);
    localparam int CNT_W  = $clog2(MAX_SECT + 1);
    localparam int STEP_W = $clog2(UNLOCK_STEPS + MAX_SECT + 1);
    localparam int SC_W   = $clog2(STROBE_CYC + 1);

    logic [STEP_W-1:0] step;
    logic [SC_W-1:0]   sc;
    logic [STEP_W-1:0] final_step;
    logic              slot_end;
    logic [ADDR_W-1:0] sect_arr [MAX_SECT];
    logic [ADDR_W-1:0] sect_pick;
    prefix_cmd_t       pc;

    for (genvar g = 0; g < MAX_SECT; g++) begin : g_unpack
        assign sect_arr[g] = sectors[g*ADDR_W +: ADDR_W];
    end

    assign final_step = STEP_W'(UNLOCK_STEPS) + STEP_W'(count) - STEP_W'(1);
    assign slot_end   = active && (sc == SC_W'(STROBE_CYC));
    assign last       = slot_end && (step == final_step);
    assign wr_strobe  = active && (sc < SC_W'(STROBE_CYC));

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            step <= '0;
            sc   <= '0;
        end else if (slot_end) begin
            sc   <= '0;
            step <= step + STEP_W'(1);
        end else begin
            sc   <= sc + SC_W'(1);
        end
    end

    always_comb begin
        sect_pick = '0;
        for (int g = 0; g < MAX_SECT; g++) begin
            if (step == STEP_W'(UNLOCK_STEPS + g)) sect_pick = sect_arr[g];
        end
    end

    assign pc = prefix_cmd(3'(step));

    always_comb begin
        if (step < STEP_W'(UNLOCK_STEPS)) begin
            wr_addr = ADDR_W'(pc.addr);
            wr_data = DATA_W'(pc.data);
        end else begin
            wr_addr = sect_pick;
            wr_data = DATA_W'(SECT_DATA);
        end
    end

    // R2: address and data held across strobe and recovery of one slot
    a_r2_slot_stable: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active) && $past(wr_strobe)) |-> ($stable(wr_addr) && $stable(wr_data)));

    // R3: the next strobe begins right after a recovery cycle
    a_r3_no_idle_gap: assert property (@(posedge clk) disable iff (rst)
        (slot_end && !last) |=> wr_strobe);

endmodule

// File: rtl/wipe_watch.sv
module wipe_watch
    import wipe_pkg::*;
#(
    parameter int POLL_GAP    = 8,
    parameter int TIMEOUT_CYC = 4000
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic use_rdy,
    input  logic rd_status,
    input  logic ry_by,
    output logic rd_cycle,
    output logic hit,
    output logic tout
);
    localparam int GAP_W = $clog2(POLL_GAP + 1);
    localparam int T_W   = $clog2(TIMEOUT_CYC + 1);

    watch_phase_e     phase;
    logic [GAP_W-1:0] gc;
    logic [T_W-1:0]   tcnt;
    logic             gap_end;

    assign gap_end  = active && (phase == PH_GAP) && (gc == GAP_W'(POLL_GAP - 1));
    assign rd_cycle = active && (phase == PH_READ);
    assign hit      = use_rdy ? (gap_end && ry_by) : (rd_cycle && rd_status);
    assign tout     = active && (tcnt == T_W'(TIMEOUT_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            phase <= PH_GAP;
            gc    <= '0;
            tcnt  <= '0;
        end else begin
            tcnt <= tcnt + T_W'(1);
            if (phase == PH_GAP) begin
                if (gap_end) begin
                    gc <= '0;
                    if (!use_rdy) phase <= PH_READ;
                end else begin
                    gc <= gc + GAP_W'(1);
                end
            end else begin
                phase <= PH_GAP;
                gc    <= '0;
            end
        end
    end

    // R4: a read lasts a single cycle
    a_r4_single_read: assert property (@(posedge clk) disable iff (rst)
        rd_cycle |=> !rd_cycle);

    // R5: ready/busy mode never reads
    a_r5_no_reads: assert property (@(posedge clk) disable iff (rst)
        (active && use_rdy) |-> !rd_cycle);

    // R6: wait counter stays within its limit
    a_r6_bounded_wait: assert property (@(posedge clk) disable iff (rst)
        active |-> (tcnt < T_W'(TIMEOUT_CYC)));

endmodule

// File: rtl/sector_wipe_ctrl.sv
module sector_wipe_ctrl
    import wipe_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int MAX_SECT    = 4,
    parameter int STROBE_CYC  = 2,
    parameter int POLL_GAP    = 8,
    parameter int TIMEOUT_CYC = 4000,
    localparam int CNT_W      = $clog2(MAX_SECT + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [CNT_W-1:0]           req_count,
    input  logic                       req_use_rdy,
    input  logic [MAX_SECT*ADDR_W-1:0] req_sectors,
    output logic [ADDR_W-1:0]          fl_addr,
    output logic [DATA_W-1:0]          fl_wdata,
    output logic                       fl_we_n,
    output logic                       fl_oe_n,
    input  logic [DATA_W-1:0]          fl_rdata,
    input  logic                       fl_ry_by,
    output logic                       fl_own,
    output logic                       done,
    output logic                       done_err
);
    ctl_state_e                  state;
    logic [CNT_W-1:0]            cnt_q;
    logic [MAX_SECT*ADDR_W-1:0]  sect_q;
    logic [ADDR_W-1:0]           poll_q;
    logic                        rdy_mode_q;
    logic                        err_q;
    logic                        accept;
    logic                        count_ok;

    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              wr_strobe;
    logic              wr_last;
    logic              rd_cycle;
    logic              hit;
    logic              tout;
    logic              rdata_unused;

    assign accept   = (state == ST_IDLE) && req_valid;
    assign count_ok = (req_count != '0) && (req_count <= CNT_W'(MAX_SECT));
    assign rdata_unused = ^fl_rdata;

    wipe_write_seq #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .MAX_SECT  (MAX_SECT),
        .STROBE_CYC(STROBE_CYC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .active   (state == ST_WRITE),
        .count    (cnt_q),
        .sectors  (sect_q),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_strobe(wr_strobe),
        .last     (wr_last)
    );

    wipe_watch #(
        .POLL_GAP   (POLL_GAP),
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_watch (
        .clk      (clk),
        .rst      (rst),
        .active   (state == ST_WATCH),
        .use_rdy  (rdy_mode_q),
        .rd_status(fl_rdata[POLL_BIT]),
        .ry_by    (fl_ry_by),
        .rd_cycle (rd_cycle),
        .hit      (hit),
        .tout     (tout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt_q      <= '0;
            sect_q     <= '0;
            poll_q     <= '0;
            rdy_mode_q <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cnt_q      <= req_count;
                        sect_q     <= req_sectors;
                        poll_q     <= req_sectors[ADDR_W-1:0];
                        rdy_mode_q <= req_use_rdy;
                        err_q      <= !count_ok;
                        state      <= count_ok ? ST_WRITE : ST_DONE;
                    end
                end
                ST_WRITE: begin
                    if (wr_last) state <= ST_WATCH;
                end
                ST_WATCH: begin
                    if (hit) begin
                        err_q <= 1'b0;
                        state <= ST_DONE;
                    end else if (tout) begin
                        err_q <= 1'b1;
                        state <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        fl_addr  = '0;
        fl_wdata = '0;
        fl_we_n  = 1'b1;
        fl_oe_n  = 1'b1;
        fl_own   = 1'b0;
        if (state == ST_WRITE) begin
            fl_own   = 1'b1;
            fl_addr  = wr_addr;
            fl_wdata = wr_data;
            fl_we_n  = !wr_strobe;
        end else if ((state == ST_WATCH) && rd_cycle) begin
            fl_own  = 1'b1;
            fl_addr = poll_q;
            fl_oe_n = 1'b0;
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign done      = (state == ST_DONE);
    assign done_err  = (state == ST_DONE) && err_q;

    // R11: strobe and read enable never overlap
    a_r11_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(!fl_we_n && !fl_oe_n));

    // R11: released bus is quiet
    a_r11_released_quiet: assert property (@(posedge clk) disable iff (rst)
        !fl_own |-> (fl_we_n && fl_oe_n && (fl_addr == '0) && (fl_wdata == '0)));

    // R4: held poll address does not move during an operation
    a_r4_poll_hold: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> ((state == ST_IDLE) || $stable(poll_q)));

    // R7: done is a single-cycle pulse followed by ready
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready));

    // R8: bad count ends at once with an error
    a_r8_bad_count: assert property (@(posedge clk) disable iff (rst)
        (accept && !count_ok) |=> (done && done_err && !fl_own));

endmodule

// File: tb/tb_sector_wipe_ctrl.sv
`timescale 1ns/1ps
module tb_sector_wipe_ctrl;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int NS = 4;
    localparam int SC = 2;
    localparam int PG = 5;
    localparam int TO = 120;
    localparam int CW = $clog2(NS + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [CW-1:0]   req_count = '0;
    logic            req_use_rdy = 1'b0;
    logic [NS*AW-1:0] req_sectors = '0;
    logic [AW-1:0]   fl_addr;
    logic [DW-1:0]   fl_wdata;
    logic            fl_we_n, fl_oe_n, fl_own, done, done_err;
    logic [DW-1:0]   fl_rdata;
    logic            fl_ry_by;

    int vectors = 0;
    int miscompares = 0;
    bit cmp_on = 1'b0;

    // reference model state
    int m_st = 0;
    int m_t = 0;
    int m_cnt = 0;
    bit m_err = 1'b0;
    bit m_rdy = 1'b0;
    logic [AW-1:0] m_sect [NS];
    logic [AW-1:0] m_poll = '0;
    int fbusy = 0;
    int busy_len = 0;

    // behavioural flash: busy for busy_len cycles after the last command
    assign fl_ry_by = (fbusy == 0);
    assign fl_rdata = (!fl_oe_n && fbusy == 0 && fl_addr == m_poll) ? 8'h80 : 8'h00;

    sector_wipe_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .MAX_SECT(NS), .STROBE_CYC(SC),
        .POLL_GAP(PG), .TIMEOUT_CYC(TO)
    ) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_count(req_count), .req_use_rdy(req_use_rdy), .req_sectors(req_sectors),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
        .fl_rdata(fl_rdata), .fl_ry_by(fl_ry_by), .fl_own(fl_own),
        .done(done), .done_err(done_err)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // timeline model, updated on every rising edge
    always @(posedge clk) begin
        bit hit;
        if (rst) begin
            m_st  <= 0;
            m_t   <= 0;
            m_err <= 1'b0;
            fbusy <= 0;
        end else begin
            case (m_st)
                0: if (req_valid) begin
                    m_cnt  <= int'(req_count);
                    m_rdy  <= req_use_rdy;
                    m_poll <= req_sectors[AW-1:0];
                    for (int i = 0; i < NS; i++) m_sect[i] <= req_sectors[i*AW +: AW];
                    if (req_count == 0 || int'(req_count) > NS) begin
                        m_st <= 3; m_err <= 1'b1;
                    end else begin
                        m_st <= 1; m_t <= 0; m_err <= 1'b0;
                    end
                end
                1: if (m_t == (5 + m_cnt) * (SC + 1) - 1) begin
                    m_st <= 2; m_t <= 0; fbusy <= busy_len;
                end else m_t <= m_t + 1;
                2: begin
                    hit = m_rdy ? ((m_t % PG) == PG - 1 && fl_ry_by)
                                : ((m_t % (PG + 1)) == PG && fl_rdata[7]);
                    if (fbusy > 0) fbusy <= fbusy - 1;
                    if (hit) begin m_st <= 3; m_err <= 1'b0; end
                    else if (m_t == TO - 1) begin m_st <= 3; m_err <= 1'b1; end
                    else m_t <= m_t + 1;
                end
                default: m_st <= 0;
            endcase
        end
    end

    // per-cycle comparison of every output against the model
    always @(negedge clk) begin
        logic [AW-1:0] ea;
        logic [DW-1:0] ed;
        logic ewe, eoe, eown, erdy, edone, eerr;
        string tag;
        int slot, sub;
        if (cmp_on) begin
            ea = '0; ed = '0; ewe = 1; eoe = 1; eown = 0; erdy = 0; edone = 0; eerr = 0;
            tag = "R1 R9";
            case (m_st)
                0: erdy = 1;
                1: begin
                    tag = "R2 R3";
                    slot = m_t / (SC + 1);
                    sub  = m_t % (SC + 1);
                    eown = 1;
                    ewe  = (sub < SC) ? 1'b0 : 1'b1;
                    case (slot)
                        0: begin ea = 16'h555; ed = 8'hAA; end
                        1: begin ea = 16'h2AA; ed = 8'h55; end
                        2: begin ea = 16'h555; ed = 8'h80; end
                        3: begin ea = 16'h555; ed = 8'hAA; end
                        4: begin ea = 16'h2AA; ed = 8'h55; end
                        default: begin ea = m_sect[slot - 5]; ed = 8'h30; end
                    endcase
                end
                2: begin
                    tag = m_rdy ? "R5 R11" : "R4 R11";
                    if (!m_rdy && (m_t % (PG + 1)) == PG) begin
                        eown = 1; eoe = 0; ea = m_poll;
                    end
                end
                default: begin tag = "R7"; edone = 1; eerr = m_err; end
            endcase
            check(tag, {34'd0, req_ready, fl_addr, fl_wdata, fl_we_n, fl_oe_n, fl_own, done, done_err},
                       {34'd0, erdy, ea, ed, ewe, eoe, eown, edone, eerr});
        end
    end

    task automatic wait_done(input string tag, input logic exp_err);
        int waited = 0;
        while (!done && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        check(tag, {63'd0, done}, 64'd1);
        check(tag, {63'd0, done_err}, {63'd0, exp_err});
        @(negedge clk);
    endtask

    task automatic issue(input int cnt, input logic [NS*AW-1:0] secs, input logic mode, input int blen);
        @(negedge clk);
        busy_len    = blen;
        req_count   = CW'(cnt);
        req_sectors = secs;
        req_use_rdy = mode;
        req_valid   = 1'b1;
        @(negedge clk);
        req_valid   = 1'b0;
    endtask

    localparam logic [NS*AW-1:0] SECS_A = {16'h7000, 16'h5000, 16'h3000, 16'h1000};
    localparam logic [NS*AW-1:0] SECS_B = {16'h0E00, 16'h0C00, 16'h0A40, 16'h4820};

    initial begin
        @(posedge clk);
        cmp_on = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle state after reset
        check("R1", {58'd0, req_ready, fl_we_n, fl_oe_n, fl_own, done, done_err}, 64'b111000);
        check("R1", {40'd0, fl_addr, fl_wdata}, 64'd0);

        // R3 R4: one sector, status polling
        issue(1, SECS_A, 1'b0, 20);
        wait_done("R4", 1'b0);
        // R3 R4: all sectors, status polling
        issue(4, SECS_B, 1'b0, 47);
        wait_done("R4", 1'b0);
        // R5: ready/busy mode, two sectors
        issue(2, SECS_A, 1'b1, 17);
        wait_done("R5", 1'b0);
        // R6: completion on the last waiting cycle wins, both modes
        issue(3, SECS_B, 1'b0, TO - 1);
        wait_done("R6", 1'b0);
        issue(3, SECS_B, 1'b1, TO - 1);
        wait_done("R6", 1'b0);
        // R6: timeout in both modes
        issue(2, SECS_A, 1'b0, TO);
        wait_done("R6", 1'b1);
        issue(1, SECS_B, 1'b1, 1000);
        wait_done("R6", 1'b1);
        // R8: illegal counts
        issue(0, SECS_A, 1'b0, 5);
        wait_done("R8", 1'b1);
        issue(5, SECS_A, 1'b0, 5);
        wait_done("R8", 1'b1);

        // R9: request while busy is ignored
        issue(2, SECS_B, 1'b1, 9);
        req_count = '0;
        req_valid = 1'b1;
        for (int k = 0; k < 4; k++) begin
            check("R9", {63'd0, req_ready}, 64'd0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        wait_done("R9", 1'b0);

        // R10: reset mid-write, then a full restart
        issue(3, SECS_A, 1'b0, 12);
        repeat (6) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10", {58'd0, req_ready, fl_we_n, fl_oe_n, fl_own, done, done_err}, 64'b111000);
        issue(3, SECS_A, 1'b0, 12);
        check("R10", {39'd0, fl_we_n, fl_addr, fl_wdata}, {39'd0, 1'b0, 16'h555, 8'hAA});
        wait_done("R10", 1'b0);

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL R7 watchdog got=hung exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule